// File: doc/BRIEF.md
# NAND Page Operation Sequencer

This block turns a single start request into the full bus sequence a raw NAND flash device needs. It supports four operations: page read, page program, block erase and device reset. It drives a command latch, an address latch, write and read strobes and a 16-bit data bus. A block index and a page index are combined into a linear byte address using two configurable shift amounts. Main-area and spare-area words move through FIFO-style pop and push ports. After each operation the block polls the device status until the device reports ready or a retry budget runs out.

Each bus cycle lasts one clock. A command cycle raises `nand_cle_o` with `nand_we_o`, and an address cycle raises `nand_ale_o` with `nand_we_o`. A write-data cycle raises `nand_we_o` alone. A read cycle raises `nand_re_o`, and the device value on `nand_dq_i` is taken at the end of that cycle. Commands and address bytes travel on `nand_dq_o[7:0]` with the upper byte zero. Completion is reported by a one-cycle `done_o` pulse with the timeout and failure flags valid.

Top module: `nand_op_seq`

## Requirements
- R1: The byte address is (block << BLK_SHIFT) + (page << PAGE_SHIFT). A read or program sends five address cycles, each taking the low bits of the address before shifting it right: 8 bits, then 3, then 8, then 8, then 1. With the default shifts of 17 and 11, the cycles carry bits [7:0], [10:8], [18:11], [26:19] and [27].
- R2: op 0 (read) sends command 0x00, five address cycles and command 0x30, then polls status. Once ready, it sends command 0x00 again and performs MAIN_WORDS + SPARE_WORDS read cycles. Each read word appears on `rdata_o` with `rdata_valid_o` high in its cycle. Status bit 0 never sets `fail_o` for a read.
- R3: op 1 (program) sends command 0x80 and five address cycles. It then performs MAIN_WORDS + SPARE_WORDS write cycles, each driving `wdata_i` and pulsing `wdata_pop_o`. It then sends command 0x10 and polls. A ready status with bit 0 set gives `fail_o`=1.
- R4: op 2 (erase) sends command 0x60 and three 8-bit row cycles taken from the address shifted right by 11. The page input is ignored and treated as zero. It then sends command 0xD0 and polls. A ready status with bit 0 set gives `fail_o`=1.
- R5: A status read is a command cycle 0x70 followed by one read cycle with `rdata_valid_o` low. For read, program and erase, the device is ready when bit 6 is set.
- R6: If MAX_POLLS consecutive status reads during a read, program or erase all report not ready, the operation ends with `timeout_o`=1 and `fail_o`=0.
- R7: op 3 (reset) sends command 0xFF with no address cycles and then leaves RESET_WAIT+1 idle cycles. It then polls until bits 6 and 5 are both set; bit 6 alone is not ready. With `ext_verify_i` set at start, RESET_TRIES not-ready reads end the operation with `timeout_o`=1. Without `ext_verify_i`, polling has no limit.
- R8: A start request while an operation is in progress is ignored and does not alter the running sequence.
- R9: `busy_o` is high from the first bus cycle through the done cycle. `done_o` is high for exactly one cycle. `timeout_o` and `fail_o` are valid in the done cycle and cleared by the next accepted start.
- R10: Exactly `poll_gap_i`+1 idle bus cycles precede every status command.
- R11: After reset the block is idle: no strobe active, `nand_dq_o`=0, and busy, done, timeout and fail all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| op_i | input | 2 | 0 read, 1 program, 2 erase, 3 reset |
| ext_verify_i | input | 1 | Bound reset polling to RESET_TRIES reads |
| blk_i | input | BLK_W | Block index |
| page_i | input | PAGE_W | Page index within block |
| poll_gap_i | input | GAP_W | Idle cycles minus one before each status command |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_o | output | 1 | Write strobe |
| nand_re_o | output | 1 | Read strobe |
| nand_dq_o | output | 16 | Data bus towards device |
| nand_dq_i | input | 16 | Data bus from device |
| wdata_i | input | 16 | Head word of the program data source |
| wdata_pop_o | output | 1 | Consume one program word |
| rdata_o | output | 16 | Read word |
| rdata_valid_o | output | 1 | Read word valid |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Polling budget ran out |
| fail_o | output | 1 | Device reported program or erase failure |

## Verification
The first bus cycle is due one clock after the start is sampled. Each command, address and data cycle then takes one clock. Each poll wait takes `poll_gap_i`+1 clocks, and the reset wait takes RESET_WAIT+1 clocks. `done_o` rises one clock after the deciding status read or the last data read. The bench expands every request into this per-cycle stream of expected bus kinds and values and compares the ports at every falling edge. The simple device model in the bench presents each status and data value from one clock after the preceding read until the next read.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RESET = 2'd3
  } nand_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD_A,
    ST_ADDR,
    ST_WR,
    ST_CMD_B,
    ST_LWAIT,
    ST_GAP,
    ST_SCMD,
    ST_SRD,
    ST_RECMD,
    ST_RD,
    ST_DONE
  } seq_st_e;

  localparam logic [7:0] CMD_RD       = 8'h00;
  localparam logic [7:0] CMD_RD_GO    = 8'h30;
  localparam logic [7:0] CMD_PRG      = 8'h80;
  localparam logic [7:0] CMD_PRG_GO   = 8'h10;
  localparam logic [7:0] CMD_ERS      = 8'h60;
  localparam logic [7:0] CMD_ERS_GO   = 8'hD0;
  localparam logic [7:0] CMD_STAT     = 8'h70;
  localparam logic [7:0] CMD_RST      = 8'hFF;

  localparam logic [7:0] RDY_MASK     = 8'h40;
  localparam logic [7:0] RST_RDY_MASK = 8'h60;

  localparam int COL_BITS    = 11;
  localparam int PAGE_CYCLES = 5;
  localparam int ROW_CYCLES  = 3;

endpackage

// File: rtl/nand_addr_gen.sv
module nand_addr_gen
  import nand_seq_pkg::*;
#(
  parameter int BLK_W      = 11,
  parameter int PAGE_W     = 6,
  parameter int BLK_SHIFT  = 17,
  parameter int PAGE_SHIFT = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              row_only_i,
  input  logic [2:0]        idx_i,
  output logic [7:0]        byte_o
);

  localparam int BLK_TOP  = BLK_SHIFT + BLK_W;
  localparam int PAGE_TOP = PAGE_SHIFT + PAGE_W;
  localparam int ADDR_W   = ((BLK_TOP > PAGE_TOP) ? BLK_TOP : PAGE_TOP) + 1;
  localparam int PAD_W    = ADDR_W + COL_BITS + 8 * ROW_CYCLES;

  logic [ADDR_W-1:0] addr_q;
  logic              row_q;
  logic [PAD_W-1:0]  pad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      row_q  <= 1'b0;
    end else if (capture_i) begin
      addr_q <= (ADDR_W'(blk_i) << BLK_SHIFT) + (ADDR_W'(page_i) << PAGE_SHIFT);
      row_q  <= row_only_i;
    end
  end

  assign pad = PAD_W'(addr_q);

  // page layout: 8,3,8,8,1 bit fields; row layout: 8-bit fields above column
  always_comb begin
    byte_o = 8'h00;
    if (row_q) begin
      byte_o = pad[COL_BITS + 8 * int'(idx_i) +: 8];
    end else begin
      case (idx_i)
        3'd0:    byte_o = pad[7:0];
        3'd1:    byte_o = {5'b0, pad[10:8]};
        3'd2:    byte_o = pad[18:11];
        3'd3:    byte_o = pad[26:19];
        default: byte_o = {7'b0, pad[27]};
      endcase
    end
  end

endmodule

// File: rtl/nand_poll_timer.sv
module nand_poll_timer #(
  parameter int CNT_W  = 17,
  parameter int POLL_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  input  logic              clr_polls_i,
  input  logic              inc_polls_i,
  output logic              zero_o,
  output logic [POLL_W-1:0] polls_o
);

  logic [CNT_W-1:0]  cnt_q;
  logic [POLL_W-1:0] polls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // saturating so unbounded reset polling never wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      polls_q <= '0;
    end else if (clr_polls_i) begin
      polls_q <= '0;
    end else if (inc_polls_i && (polls_q != '1)) begin
      polls_q <= polls_q + 1'b1;
    end
  end

  assign zero_o  = (cnt_q == '0);
  assign polls_o = polls_q;

  a_r10_gap_holds_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_seq_pkg::*;
#(
  parameter int BLK_W       = 11,
  parameter int PAGE_W      = 6,
  parameter int BLK_SHIFT   = 17,
  parameter int PAGE_SHIFT  = 11,
  parameter int MAIN_WORDS  = 1024,
  parameter int SPARE_WORDS = 32,
  parameter int MAX_POLLS   = 1500,
  parameter int RESET_WAIT  = 100000,
  parameter int RESET_TRIES = 20000,
  parameter int GAP_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              ext_verify_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [GAP_W-1:0]  poll_gap_i,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_o,
  output logic              nand_re_o,
  output logic [15:0]       nand_dq_o,
  input  logic [15:0]       nand_dq_i,
  input  logic [15:0]       wdata_i,
  output logic              wdata_pop_o,
  output logic [15:0]       rdata_o,
  output logic              rdata_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              fail_o
);

  localparam int XFER_WORDS = MAIN_WORDS + SPARE_WORDS;
  localparam int XFER_W     = $clog2(XFER_WORDS + 1);
  localparam int POLL_LIM   = (MAX_POLLS > RESET_TRIES) ? MAX_POLLS : RESET_TRIES;
  localparam int POLL_W     = $clog2(POLL_LIM + 2);
  localparam int WAIT_W     = $clog2(RESET_WAIT + 1);
  localparam int CNT_W      = (WAIT_W > GAP_W) ? WAIT_W : GAP_W;

  seq_st_e           st_q, st_d;
  nand_op_e          op_q;
  logic              ext_q;
  logic [2:0]        idx_q;
  logic [XFER_W-1:0] wcnt_q;
  logic              timeout_q, fail_q;

  logic              start_ok;
  logic              last_addr, last_word;
  logic [7:0]        stat_mask;
  logic              rdy, limited, hit;
  logic [POLL_W-1:0] lim_val;
  logic              t_load, t_zero, clr_polls, inc_polls;
  logic [CNT_W-1:0]  t_val;
  logic [POLL_W-1:0] polls;
  logic [7:0]        addr_byte;
  logic [PAGE_W-1:0] page_eff;

  assign start_ok  = (st_q == ST_IDLE) && start_i;
  assign page_eff  = (nand_op_e'(op_i) == OP_ERASE) ? '0 : page_i;
  assign last_addr = (op_q == OP_ERASE) ? (idx_q == 3'(ROW_CYCLES - 1))
                                        : (idx_q == 3'(PAGE_CYCLES - 1));
  assign last_word = (wcnt_q == XFER_W'(XFER_WORDS - 1));
  assign stat_mask = (op_q == OP_RESET) ? RST_RDY_MASK : RDY_MASK;
  assign rdy       = ((nand_dq_i[7:0] & stat_mask) == stat_mask);
  assign limited   = (op_q != OP_RESET) || ext_q;
  assign lim_val   = (op_q == OP_RESET) ? POLL_W'(RESET_TRIES) : POLL_W'(MAX_POLLS);
  assign hit       = limited && ((polls + POLL_W'(1)) == lim_val);

  nand_addr_gen #(
    .BLK_W     (BLK_W),
    .PAGE_W    (PAGE_W),
    .BLK_SHIFT (BLK_SHIFT),
    .PAGE_SHIFT(PAGE_SHIFT)
  ) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (start_ok),
    .blk_i     (blk_i),
    .page_i    (page_eff),
    .row_only_i(nand_op_e'(op_i) == OP_ERASE),
    .idx_i     (idx_q),
    .byte_o    (addr_byte)
  );

  nand_poll_timer #(
    .CNT_W (CNT_W),
    .POLL_W(POLL_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .clr_polls_i(clr_polls),
    .inc_polls_i(inc_polls),
    .zero_o     (t_zero),
    .polls_o    (polls)
  );

  always_comb begin
    st_d      = st_q;
    t_load    = 1'b0;
    t_val     = '0;
    clr_polls = 1'b0;
    inc_polls = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d      = ST_CMD_A;
        clr_polls = 1'b1;
      end
      ST_CMD_A: if (op_q == OP_RESET) begin
        st_d   = ST_LWAIT;
        t_load = 1'b1;
        t_val  = CNT_W'(RESET_WAIT);
      end else begin
        st_d = ST_ADDR;
      end
      ST_ADDR: if (last_addr) st_d = (op_q == OP_PROG) ? ST_WR : ST_CMD_B;
      ST_WR:   if (last_word) st_d = ST_CMD_B;
      ST_CMD_B: begin
        st_d   = ST_GAP;
        t_load = 1'b1;
        t_val  = CNT_W'(poll_gap_i);
      end
      ST_LWAIT: if (t_zero) begin
        st_d   = ST_GAP;
        t_load = 1'b1;
        t_val  = CNT_W'(poll_gap_i);
      end
      ST_GAP:  if (t_zero) st_d = ST_SCMD;
      ST_SCMD: st_d = ST_SRD;
      ST_SRD: begin
        inc_polls = 1'b1;
        if (rdy) begin
          st_d = (op_q == OP_READ) ? ST_RECMD : ST_DONE;
        end else if (hit) begin
          st_d = ST_DONE;
        end else begin
          st_d   = ST_GAP;
          t_load = 1'b1;
          t_val  = CNT_W'(poll_gap_i);
        end
      end
      ST_RECMD: st_d = ST_RD;
      ST_RD:    if (last_word) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_READ;
      ext_q     <= 1'b0;
      idx_q     <= '0;
      wcnt_q    <= '0;
      timeout_q <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= (st_q == ST_ADDR) ? idx_q + 3'd1 : 3'd0;
      wcnt_q <= (st_q == ST_WR || st_q == ST_RD) ? wcnt_q + 1'b1 : '0;
      if (start_ok) begin
        op_q      <= nand_op_e'(op_i);
        ext_q     <= ext_verify_i;
        timeout_q <= 1'b0;
        fail_q    <= 1'b0;
      end
      if (st_q == ST_SRD) begin
        if (rdy) begin
          fail_q <= ((op_q == OP_PROG) || (op_q == OP_ERASE)) && nand_dq_i[0];
        end else if (hit) begin
          timeout_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    nand_dq_o = 16'h0000;
    case (st_q)
      ST_CMD_A: case (op_q)
        OP_READ:  nand_dq_o = {8'h00, CMD_RD};
        OP_PROG:  nand_dq_o = {8'h00, CMD_PRG};
        OP_ERASE: nand_dq_o = {8'h00, CMD_ERS};
        default:  nand_dq_o = {8'h00, CMD_RST};
      endcase
      ST_CMD_B: case (op_q)
        OP_READ:  nand_dq_o = {8'h00, CMD_RD_GO};
        OP_PROG:  nand_dq_o = {8'h00, CMD_PRG_GO};
        default:  nand_dq_o = {8'h00, CMD_ERS_GO};
      endcase
      ST_ADDR:  nand_dq_o = {8'h00, addr_byte};
      ST_SCMD:  nand_dq_o = {8'h00, CMD_STAT};
      ST_RECMD: nand_dq_o = {8'h00, CMD_RD};
      ST_WR:    nand_dq_o = wdata_i;
      default:  nand_dq_o = 16'h0000;
    endcase
  end

  assign nand_cle_o    = (st_q == ST_CMD_A) || (st_q == ST_CMD_B) ||
                         (st_q == ST_SCMD)  || (st_q == ST_RECMD);
  assign nand_ale_o    = (st_q == ST_ADDR);
  assign nand_we_o     = nand_cle_o || nand_ale_o || (st_q == ST_WR);
  assign nand_re_o     = (st_q == ST_SRD) || (st_q == ST_RD);
  assign wdata_pop_o   = (st_q == ST_WR);
  assign rdata_o       = nand_dq_i;
  assign rdata_valid_o = (st_q == ST_RD);
  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = (st_q == ST_DONE);
  assign timeout_o     = timeout_q;
  assign fail_o        = fail_q;

  a_r5_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nand_cle_o, nand_ale_o, nand_re_o}) && !(nand_re_o && nand_we_o));

  a_r3_pop_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_pop_o |-> (nand_we_o && !nand_cle_o && !nand_ale_o && op_q == OP_PROG));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(timeout_o && fail_o));

  a_r8_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(op_q));

  a_r6_poll_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && timeout_o && op_q != OP_RESET) |-> (polls == POLL_W'(MAX_POLLS)));

  a_r7_reset_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && timeout_o && op_q == OP_RESET) |-> (ext_q && polls == POLL_W'(RESET_TRIES)));

endmodule

// File: tb/nand_op_seq_test.sv
module nand_op_seq_test;

  localparam int BLK_W = 11, PAGE_W = 6, GAP_W = 16;
  localparam int MAIN_WORDS = 8, SPARE_WORDS = 2;
  localparam int MAX_POLLS = 4, RESET_WAIT = 5, RESET_TRIES = 3;

  // event kinds in the expected per-cycle stream
  localparam int K_IDLE = 0, K_CMD = 1, K_ADDR = 2, K_WR = 3, K_STAT = 4, K_RD = 5, K_DONE = 6, K_BAD = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, start, ext_verify;
  logic [1:0]        op;
  logic [BLK_W-1:0]  blk;
  logic [PAGE_W-1:0] page;
  logic [GAP_W-1:0]  gap;
  logic              cle, ale, we, re, pop, rvalid, busy, done, tmo, fail;
  logic [15:0]       dq_o, dq_i, wdata, rdata;

  nand_op_seq #(
    .BLK_W(BLK_W), .PAGE_W(PAGE_W), .MAIN_WORDS(MAIN_WORDS), .SPARE_WORDS(SPARE_WORDS),
    .MAX_POLLS(MAX_POLLS), .RESET_WAIT(RESET_WAIT), .RESET_TRIES(RESET_TRIES), .GAP_W(GAP_W)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .ext_verify_i(ext_verify),
    .blk_i(blk), .page_i(page), .poll_gap_i(gap),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_o(we), .nand_re_o(re),
    .nand_dq_o(dq_o), .nand_dq_i(dq_i), .wdata_i(wdata), .wdata_pop_o(pop),
    .rdata_o(rdata), .rdata_valid_o(rvalid), .busy_o(busy), .done_o(done),
    .timeout_o(tmo), .fail_o(fail)
  );

  int checks = 0, errors = 0, cyc = 0;
  int ek[$], ev[$], er[$];
  logic [15:0] resp_q[$], wsrc[$], stat_in[$], data_in[$];
  int widx = 0;
  logic re_prev = 1'b0, pop_prev = 1'b0;

  // device model: holds each value from one clock after the previous read
  always @(posedge clk) begin
    #1;
    if (re_prev && resp_q.size() > 0) void'(resp_q.pop_front());
    dq_i = (resp_q.size() > 0) ? resp_q[0] : 16'h0000;
    re_prev = re;
    if (pop_prev) widx++;
    wdata = (widx < wsrc.size()) ? wsrc[widx] : 16'h0000;
    pop_prev = pop;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input int req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ex(input int k, input int v, input int r);
    ek.push_back(k); ev.push_back(v); er.push_back(r);
  endtask

  // R10: poll gap idles
  task automatic ex_gap(input int g);
    for (int i = 0; i <= g; i++) ex(K_IDLE, 0, 10);
  endtask

  // R5: status command then one status read
  task automatic ex_polls(input int g);
    foreach (stat_in[i]) begin
      ex_gap(g);
      ex(K_CMD, 'h70, 5);
      ex(K_STAT, 0, 5);
      resp_q.push_back(stat_in[i]);
    end
  endtask

  // R1: five page cycles, low bits then shift: 8,3,8,8,1
  task automatic ex_page_addr(input int b, input int p);
    longint a = (longint'(b) << 17) + (longint'(p) << 11);
    ex(K_ADDR, int'(a & 255), 1); a = a >> 8;
    ex(K_ADDR, int'(a & 7), 1);   a = a >> 3;
    ex(K_ADDR, int'(a & 255), 1); a = a >> 8;
    ex(K_ADDR, int'(a & 255), 1); a = a >> 8;
    ex(K_ADDR, int'(a & 1), 1);
  endtask

  // R4: row cycles use page zero, column dropped
  task automatic ex_row_addr(input int b);
    longint a = (longint'(b) << 17) >> 11;
    for (int i = 0; i < 3; i++) begin
      ex(K_ADDR, int'(a & 255), 4);
      a = a >> 8;
    end
  endtask

  function automatic int obs_kind();
    if (done && !(cle || ale || we || re)) return K_DONE;
    if (re && !we && !cle && !ale) return rvalid ? K_RD : K_STAT;
    if (we && cle && !ale && !re) return K_CMD;
    if (we && ale && !cle && !re) return K_ADDR;
    if (we && pop && !cle && !ale && !re) return K_WR;
    if (!(cle || ale || we || re || done || pop || rvalid)) return K_IDLE;
    return K_BAD;
  endfunction

  function automatic int obs_val(input int k);
    case (k)
      K_CMD, K_ADDR, K_WR: return int'(dq_o);
      K_RD:                return int'(rdata);
      K_DONE:              return int'({fail, tmo});
      default:             return 0;
    endcase
  endfunction

  // called at a falling edge; runs the expected stream cycle by cycle
  task automatic run(input int o, input bit x, input int b, input int p, input int g, input int poke_at);
    int k, v;
    op = 2'(o); ext_verify = x; blk = BLK_W'(b); page = PAGE_W'(p); gap = GAP_W'(g);
    widx = 0; start = 1'b1;
    for (int i = 0; i < ek.size(); i++) begin
      @(negedge clk);
      start = 1'b0;
      if (i == poke_at) begin
        start = 1'b1;
        op = 2'd0;
        blk = ~blk;
      end
      k = obs_kind();
      v = obs_val(k);
      chk(k == ek[i] && v == ev[i] && busy, er[i], $sformatf("cycle %0d kind/val", i),
          (k << 20) | (v & 'hFFFFF) | (int'(busy) << 28), (ek[i] << 20) | ev[i] | (1 << 28));
    end
    @(negedge clk);
    start = 1'b0;
    // R9: back to idle right after the done pulse
    chk(!busy && !done, 9, "idle after done", int'({busy, done}), 0);
    ek.delete(); ev.delete(); er.delete(); stat_in.delete(); data_in.delete();
  endtask

  task automatic build_read(input int b, input int p, input int g);
    ex(K_CMD, 'h00, 2); ex_page_addr(b, p); ex(K_CMD, 'h30, 2);
    ex_polls(g);
    ex(K_CMD, 'h00, 2);
    foreach (data_in[i]) begin
      ex(K_RD, int'(data_in[i]), 2);
      resp_q.push_back(data_in[i]);
    end
    ex(K_DONE, 0, 9);
  endtask

  task automatic build_prog(input int b, input int p, input int g, input int res);
    ex(K_CMD, 'h80, 3); ex_page_addr(b, p);
    foreach (wsrc[i]) ex(K_WR, int'(wsrc[i]), 3);
    ex(K_CMD, 'h10, 3);
    ex_polls(g);
    ex(K_DONE, res, 3);
  endtask

  task automatic build_erase(input int b, input int g, input int res);
    ex(K_CMD, 'h60, 4); ex_row_addr(b); ex(K_CMD, 'hD0, 4);
    ex_polls(g);
    ex(K_DONE, res, 4);
  endtask

  task automatic build_reset(input int g, input int res);
    ex(K_CMD, 'hFF, 7);
    for (int i = 0; i <= RESET_WAIT; i++) ex(K_IDLE, 0, 7);
    ex_polls(g);
    ex(K_DONE, res, 7);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op = '0; ext_verify = 1'b0;
    blk = '0; page = '0; gap = '0; dq_i = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk(!cle && !ale && !we && !re, 11, "strobes after reset", int'({cle, ale, we, re}), 0);
    chk(dq_o == 16'h0, 11, "dq after reset", int'(dq_o), 0);
    chk(!busy && !done, 11, "busy/done after reset", int'({busy, done}), 0);
    chk(!tmo && !fail, 11, "flags after reset", int'({tmo, fail}), 0);

    // R2 read: busy once, then ready with bit0 set (no fail on read)
    stat_in = '{16'h0000, 16'h0041};
    for (int i = 0; i < MAIN_WORDS + SPARE_WORDS; i++) data_in.push_back(16'hA500 + 16'(i * 37));
    build_read('h5A3, 'h2D, 1);
    run(0, 0, 'h5A3, 'h2D, 1, -1);

    // R3 program pass, gap zero
    wsrc.delete();
    for (int i = 0; i < MAIN_WORDS + SPARE_WORDS; i++) wsrc.push_back(16'h1234 ^ 16'(i * 4099));
    stat_in = '{16'h0040};
    build_prog('h001, 'h3F, 0, 0);
    run(1, 0, 'h001, 'h3F, 0, -1);

    // R3 program fail (bit0) after two polls; R8 start while busy at cycle 3
    stat_in = '{16'h0001, 16'h0041};
    build_prog('h7FF, 'h00, 2, 2);
    run(1, 0, 'h7FF, 'h00, 2, 3);

    // R4 erase, page input nonzero must be ignored, pass
    stat_in = '{16'h0000, 16'h0000, 16'h0040};
    build_erase('h2A5, 1, 0);
    run(2, 0, 'h2A5, 'h3F, 1, -1);

    // R4 erase fail
    stat_in = '{16'h0041};
    build_erase('h7FF, 3, 2);
    run(2, 0, 'h7FF, 'h01, 3, -1);

    // R6 timeout after MAX_POLLS not-ready reads (bit0 ignored when not ready)
    stat_in = '{16'h0001, 16'h0000, 16'h00BF, 16'h0001};
    build_erase('h100, 0, 1);
    run(2, 0, 'h100, 'h00, 0, -1);

    // R6 timeout on a read, no data phase
    stat_in = '{16'h0000, 16'h0000, 16'h0000, 16'h0000};
    ex(K_CMD, 'h00, 6); ex_page_addr('h0AA, 'h15); ex(K_CMD, 'h30, 6);
    ex_polls(1); ex(K_DONE, 1, 6);
    run(0, 0, 'h0AA, 'h15, 1, -1);

    // R7 reset without extended verify: bit6 alone not ready, more polls than RESET_TRIES
    stat_in = '{16'h0040, 16'h0020, 16'h0000, 16'h00C1, 16'h0060};
    build_reset(1, 0);
    run(3, 0, 'h0, 'h0, 1, -1);

    // R7 reset with extended verify: bounded by RESET_TRIES
    stat_in = '{16'h0040, 16'h0000, 16'h0020};
    build_reset(0, 1);
    run(3, 1, 'h0, 'h0, 0, -1);

    // R2 second read pattern, larger gap, immediate ready
    stat_in = '{16'h00FF};
    for (int i = 0; i < MAIN_WORDS + SPARE_WORDS; i++) data_in.push_back(16'(16'hFFFF - i));
    build_read('h7FF, 'h3F, 4);
    run(0, 0, 'h7FF, 'h3F, 4, -1);

    // R9: flags cleared by the next accepted start (done shows fresh result)
    stat_in = '{16'h0040};
    build_erase('h003, 0, 0);
    run(2, 0, 'h003, 'h00, 0, -1);

    summary();
    $finish;
  end

endmodule